// File: doc/BRIEF.md
# Paged Write Buffer with Timed Commit

This block sits behind a serial-bus protocol engine in front of a paged nonvolatile byte array. The engine gives it a start address and then a stream of data bytes. The block gathers those bytes into a one-page staging buffer. A byte offset pointer advances after each byte and wraps inside the page, so the page number never changes during one write.

When the engine reports the STOP condition with a commit request, the block starts an internal write cycle. The cycle lasts a configurable number of clocks and holds a busy flag high the whole time. When the count expires, only the staged bytes are copied into the array and all staging flags are cleared. While the flag is high, every request from the engine is dropped.

Reads are served straight from the array, one clock after the request. The array size, page size and write-cycle length are all parameters.

Top module: `pgw_commit`

## Requirements
- R1: After reset, `busy_o` is low and every array location reads 8'hFF.
- R2: A start request loads the page from the upper `ADDR_W-PAGE_W` address bits and the byte offset from the lower `PAGE_W` bits. The first data byte lands at exactly that address.
- R3: The offset pointer advances by one after each accepted byte and wraps from the last offset to offset 0 of the same page. The page number never changes during a write.
- R4: When more bytes arrive than a page holds, a later byte replaces the earlier staged byte at the same offset. The array then holds the later value.
- R5: A commit writes only the offsets that received bytes. Every other location in the page keeps its previous contents.
- R6: A commit request with at least one staged byte and `reject_i` low raises `busy_o` on the next clock. `busy_o` then stays high for exactly `WR_CYCLES` clocks. The array holds the new data once `busy_o` has dropped.
- R7: A commit request with no staged bytes, or with `reject_i` high, leaves `busy_o` low, discards the staged bytes and leaves the array unchanged.
- R8: While `busy_o` is high, the block ignores start, data, commit and read requests. `rd_valid_o` stays low, and nothing sent during busy reaches the array.
- R9: A read request with `busy_o` low returns the array byte at `rd_addr_i` on `rd_data_o`, with `rd_valid_o` high, one clock later. Staged bytes that are not yet committed are not visible to reads.
- R10: Every staging flag is clear after a write cycle completes, so a later commit with no new bytes starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new write at `start_addr_i` |
| start_addr_i | input | ADDR_W | Byte address of the first data byte |
| wr_valid_i | input | 1 | A data byte is present on `wr_data_i` |
| wr_data_i | input | 8 | Data byte to stage |
| commit_i | input | 1 | Commit request issued at STOP |
| reject_i | input | 1 | Qualifies `commit_i`: the write was refused for write protection |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_valid_o | output | 1 | `rd_data_o` holds the answer to last cycle's request |
| rd_data_o | output | 8 | Read data |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The assertions assume that the protocol engine raises at most one of start, data and commit in any clock. They also assume that `reject_i` only has meaning in the cycle where `commit_i` is high. The bench drives each request as a single-cycle pulse on the falling edge and never overlaps two of them. The one exception is the busy interval, where it deliberately fires start, data, commit and read requests to show that they are dropped. Reads are issued only while `busy_o` is low, except in that gating test.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;
  localparam byte_t ERASED = 8'hFF;
endpackage

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int WR_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (go_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(WR_CYCLES - 1);
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CNT_W'(WR_CYCLES)));
endmodule

// File: rtl/pgw_buf.sv
module pgw_buf
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [ADDR_W-1:0]             start_addr_i,
  input  logic                          load_i,
  input  byte_t                         data_i,
  input  logic                          clear_i,
  output logic [ADDR_W-PAGE_W-1:0]      page_o,
  output logic [(1<<PAGE_W)-1:0][7:0]   slots_o,
  output logic [(1<<PAGE_W)-1:0]        valid_o,
  output logic                          any_o
);
  localparam int SLOTS = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic [PG_W-1:0]          page_q;
  logic [PAGE_W-1:0]        ptr_q;
  logic [SLOTS-1:0][7:0]    slot_q;
  logic [SLOTS-1:0]         valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q  <= '0;
      ptr_q   <= '0;
      valid_q <= '0;
    end else if (start_i) begin
      page_q  <= start_addr_i[ADDR_W-1:PAGE_W];
      ptr_q   <= start_addr_i[PAGE_W-1:0];
      valid_q <= '0;
    end else if (clear_i) begin
      valid_q <= '0;
    end else if (load_i) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q          <= ptr_q + 1'b1; // wraps inside page
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_i && !start_i && !clear_i) slot_q[ptr_q] <= data_i;
  end

  assign page_o  = page_q;
  assign slots_o = slot_q;
  assign valid_o = valid_q;
  assign any_o   = |valid_q;

  // R3
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(page_q));
endmodule

// File: rtl/pgw_array.sv
module pgw_array
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-PAGE_W-1:0]    page_i,
  input  logic [(1<<PAGE_W)-1:0][7:0] slots_i,
  input  logic [(1<<PAGE_W)-1:0]      mask_i,
  input  logic                        rd_en_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic                        rd_valid_o,
  output byte_t                       rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;

  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= ERASED;
    end else if (we_i) begin
      for (int s = 0; s < SLOTS; s++)
        if (mask_i[s]) mem_q[{page_i, PAGE_W'(s)}] <= slots_i[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= ERASED;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
    end
  end
endmodule

// File: rtl/pgw_commit.sv
module pgw_commit
  import pgw_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 8,
  parameter int WR_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              wr_valid_i,
  input  logic [7:0]        wr_data_i,
  input  logic              commit_i,
  input  logic              reject_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  localparam int SLOTS = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic                  start_ok, load_ok, commit_ok, go, discard, done, any;
  logic [PG_W-1:0]       page;
  logic [SLOTS-1:0][7:0] slots;
  logic [SLOTS-1:0]      valid;

  assign start_ok  = start_i && !busy_o;
  assign load_ok   = wr_valid_i && !busy_o && !start_i;
  assign commit_ok = commit_i && !busy_o && !start_i;
  assign go        = commit_ok && any && !reject_i;
  assign discard   = commit_ok && !go;

  pgw_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
    .clk_i, .rst_ni,
    .start_i(start_ok), .start_addr_i,
    .load_i(load_ok), .data_i(wr_data_i),
    .clear_i(done || discard),
    .page_o(page), .slots_o(slots), .valid_o(valid), .any_o(any)
  );

  pgw_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni, .go_i(go), .busy_o(busy_o), .done_o(done)
  );

  pgw_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk_i, .rst_ni,
    .we_i(done), .page_i(page), .slots_i(slots), .mask_i(valid),
    .rd_en_i(rd_req_i && !busy_o), .rd_addr_i,
    .rd_valid_o, .rd_data_o
  );

  // R6
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit_i && !reject_i));
  // R7
  no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !busy_o && !start_i && (reject_i || !any)) |=> !busy_o);
  // R8
  rd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i && !busy_o));
  // R10
  flags_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (valid == '0));
endmodule

// File: tb/pgw_commit_tb.sv
module pgw_commit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;
  localparam int PAGE_W = 8;
  localparam int WR_CYC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, wr_valid = 0, commit = 0, reject = 0, rd_req = 0;
  logic [ADDR_W-1:0] start_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_valid, busy;
  logic [7:0] rd_data;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgw_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .start_i(start), .start_addr_i(start_addr),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .commit_i(commit), .reject_i(reject),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); rd_req = 1; rd_addr = a;
    @(negedge clk); rd_req = 0;
    check(rd_valid === 1'b1, req, rd_valid, 1);
    check(rd_data === exp, req, rd_data, exp);
  endtask

  task automatic do_start(input logic [ADDR_W-1:0] a);
    @(negedge clk); start = 1; start_addr = a;
    @(negedge clk); start = 0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  // commit, then count busy cycles; returns count (0 if none)
  task automatic do_commit(input bit rej, output int n);
    @(negedge clk); commit = 1; reject = rej;
    @(negedge clk); commit = 0; reject = 0;
    n = 0;
    while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    check(busy === 1'b0, "R1 busy", busy, 0);
    rd_chk(11'h000, 8'hFF, "R1 erased");
    rd_chk(11'h7FF, 8'hFF, "R1 erased");
  endtask

  task automatic t_basic;
    int n;
    do_start(11'h123);
    do_byte(8'hA1); do_byte(8'hA2);
    rd_chk(11'h123, 8'hFF, "R9 buffer hidden");
    do_commit(0, n);
    check(n == WR_CYC, "R6 busy length", n, WR_CYC);
    rd_chk(11'h123, 8'hA1, "R2 first byte");
    rd_chk(11'h124, 8'hA2, "R6 data");
    rd_chk(11'h125, 8'hFF, "R5 untouched");
    rd_chk(11'h122, 8'hFF, "R5 untouched");
  endtask

  task automatic t_wrap;
    int n;
    do_start(11'h2FE);
    do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
    do_commit(0, n);
    check(n == WR_CYC, "R6 busy length", n, WR_CYC);
    rd_chk(11'h2FE, 8'h11, "R3 wrap");
    rd_chk(11'h2FF, 8'h22, "R3 wrap");
    rd_chk(11'h200, 8'h33, "R3 wrap same page");
    rd_chk(11'h300, 8'hFF, "R3 next page untouched");
  endtask

  task automatic t_overflow;
    int n;
    do_start(11'h400);
    for (int k = 0; k < 258; k++) do_byte(k >= 256 ? 8'(8'hC0 + k - 256) : 8'(k));
    do_commit(0, n);
    rd_chk(11'h400, 8'hC0, "R4 overwrite");
    rd_chk(11'h401, 8'hC1, "R4 overwrite");
    rd_chk(11'h402, 8'h02, "R4 kept");
    rd_chk(11'h4FF, 8'hFF, "R4 last");
  endtask

  task automatic t_reject;
    int n;
    do_start(11'h500);
    do_byte(8'h77);
    do_commit(1, n);
    check(n == 0, "R7 reject no busy", n, 0);
    do_commit(0, n);
    check(n == 0, "R7 discarded no busy", n, 0);
    rd_chk(11'h500, 8'hFF, "R7 array unchanged");
    do_start(11'h510);
    do_commit(0, n);
    check(n == 0, "R7 empty commit", n, 0);
  endtask

  task automatic t_busy_gate;
    int n;
    do_start(11'h600);
    do_byte(8'h99);
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    check(busy === 1'b1, "R6 busy rises", busy, 1);
    rd_req = 1; rd_addr = 11'h600;
    @(negedge clk); rd_req = 0;
    check(rd_valid === 1'b0, "R8 read ignored", rd_valid, 0);
    do_start(11'h700);
    do_byte(8'h44);
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    n = 0;
    while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    rd_chk(11'h600, 8'h99, "R6 committed");
    rd_chk(11'h700, 8'hFF, "R8 data ignored");
    do_commit(0, n);
    check(n == 0, "R10 flags cleared", n, 0);
    rd_chk(11'h601, 8'hFF, "R10 no extra write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_overflow();
    t_reject();
    t_busy_gate();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule